// File: doc/BRIEF.md
# Background Capacitor Trim Calibration Engine

This block keeps one trim code for each of the most-significant capacitors of a successive-approximation DAC. The trim codes feed small trim sub-DACs outside the block. During an optional calibration slot, the data-weighted-averaging pointer names the element under test. The residue amplifier then returns the polarity of the residue, and that polarity is added to a small up/down accumulator that belongs to the element. The selection comes from the shuffling pointer rather than from the converted signal, so calibration runs in the background and places no condition on the input.

A code moves by a single LSB only after the same polarity has outweighed the other by a full threshold. Isolated decisions that are corrupted by noise therefore cannot dither the trim. Calibration slots can be skipped at any time. Pulling the run control low freezes every code and accumulator, for example once the capacitors have settled. A combinational readback port returns any one code by index.

A three-state controller runs each measurement:
- IDLE: no measurement is open.
- AWAIT: a slot has been accepted and the engine waits for the polarity.
- COMMIT: the polarity is written into the chosen element.

The controller has five transitions:
- IDLE to AWAIT: on an accepted slot.
- AWAIT to COMMIT: when a polarity arrives while running.
- AWAIT to IDLE: an abort, when run drops.
- COMMIT to IDLE: always, after one cycle.
- IDLE to IDLE: otherwise.

Top module: `msb_trim_cal`

## Requirements
- R1: After reset, every trim code reads 128 and every accumulator is zero.
- R2: A slot strobe in IDLE is accepted only when `cal_run` is high and `slot_sel` is below 15. A strobe with index 15 is ignored: no code changes, and a polarity that follows it changes nothing.
- R3: A positive polarity (`sign_pos`=1) adds one to the chosen element's accumulator, and a negative polarity subtracts one. When the count would reach +8, the code rises by 1; when it would reach -8, the code falls by 1. In both cases the accumulator returns to zero. The new code is visible after the clock edge that follows the edge sampling `sign_vld`.
- R4: A measurement changes no element other than the one selected, and at most one code changes in any cycle.
- R5: A code saturates at 255 and at 0. Further threshold crossings in the same direction leave it there.
- R6: While `cal_run` is low, no slot is accepted and all codes and accumulators hold. A measurement waiting in AWAIT is aborted, and its polarity is discarded.
- R7: AWAIT lasts as long as `sign_vld` stays low. Slot strobes that arrive during AWAIT are ignored, and the polarity is applied to the element captured at the accepted strobe.
- R8: Element i's code occupies bits [8i+7:8i] of `trim_codes`. `rd_code` returns the code of element `rd_sel` in the same cycle, or 0 when `rd_sel` is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_run | input | 1 | High to run calibration, low to freeze |
| slot_stb | input | 1 | Calibration slot strobe |
| slot_sel | input | 4 | Element under test, taken from the shuffling pointer |
| sign_vld | input | 1 | Residue polarity valid |
| sign_pos | input | 1 | Residue polarity: 1 raises the code, 0 lowers it |
| trim_codes | output | 120 | All 15 trim codes, 8 bits each |
| rd_sel | input | 4 | Readback element index |
| rd_code | output | 8 | Readback code |

## Verification
The bench drives a run of seven equal polarities and confirms that the code has not moved, then checks that the eighth moves it by one. A design that stepped on every decision, or that failed to clear the count, would show up on this sequence or on the reversal that follows it. It drives one element into each rail and continues past it, which catches a code that wraps from 255 to 0. It drops `cal_run` between a strobe and its polarity, and sends strobes during a delayed wait. A design that applied an aborted measurement, or that retargeted a pending measurement to a late strobe, would move the wrong code or move a code too early. It also sends the out-of-range index 15, which a design that decoded the index without a range check would alias onto a real element.

// File: rtl/msb_trim_cal_pkg.sv
package msb_trim_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_AWAIT  = 2'd1,
        ST_COMMIT = 2'd2
    } cal_state_t;

endpackage

// File: rtl/msb_trim_cal_ctrl.sv
module msb_trim_cal_ctrl
    import msb_trim_cal_pkg::*;
#(
    parameter int N_ELEM = 15,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_run,
    input  logic             slot_stb,
    input  logic [SEL_W-1:0] slot_sel,
    input  logic             sign_vld,
    input  logic             sign_pos,
    output cal_state_t       state,
    output logic             apply_en,
    output logic [SEL_W-1:0] apply_sel,
    output logic             apply_up
);

    localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(N_ELEM);

    cal_state_t       state_nxt;
    logic [SEL_W-1:0] sel_q;
    logic             up_q;
    logic             sel_ok;

    assign sel_ok = ({1'b0, slot_sel} < SEL_LIMIT);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cal_run && slot_stb && sel_ok)
                    state_nxt = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (!cal_run)
                    state_nxt = ST_IDLE;
                else if (sign_vld)
                    state_nxt = ST_COMMIT;
            end
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= '0;
            up_q  <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && state_nxt == ST_AWAIT)
                sel_q <= slot_sel;
            if (state == ST_AWAIT && state_nxt == ST_COMMIT)
                up_q <= sign_pos;
        end
    end

    always_comb begin
        apply_en  = 1'b0;
        apply_sel = sel_q;
        apply_up  = up_q;
        unique case (state)
            ST_IDLE:   apply_en = 1'b0;
            ST_AWAIT:  apply_en = 1'b0;
            ST_COMMIT: apply_en = 1'b1;
            default:   apply_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/msb_trim_cal_cell.sv
module msb_trim_cal_cell #(
    parameter int CODE_W     = 8,
    parameter int THRESH     = 8,
    parameter int RESET_CODE = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              up,
    output logic [CODE_W-1:0] code
);

    localparam int ACC_W = $clog2(THRESH) + 2;
    localparam logic signed [ACC_W-1:0] ACC_HI = ACC_W'(THRESH - 1);
    localparam logic signed [ACC_W-1:0] ACC_LO = -ACC_HI;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

    logic signed [ACC_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            code <= CODE_RST;
        end else if (hit) begin
            if (up) begin
                if (acc == ACC_HI) begin
                    acc <= '0;
                    if (code != CODE_MAX)
                        code <= code + 1'b1;
                end else begin
                    acc <= acc + 1'b1;
                end
            end else begin
                if (acc == ACC_LO) begin
                    acc <= '0;
                    if (code != CODE_MIN)
                        code <= code - 1'b1;
                end else begin
                    acc <= acc - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/msb_trim_cal.sv
module msb_trim_cal
    import msb_trim_cal_pkg::*;
#(
    parameter int N_ELEM     = 15,
    parameter int CODE_W     = 8,
    parameter int THRESH     = 8,
    parameter int RESET_CODE = 128,
    parameter int SEL_W      = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cal_run,
    input  logic                     slot_stb,
    input  logic [SEL_W-1:0]         slot_sel,
    input  logic                     sign_vld,
    input  logic                     sign_pos,
    output logic [N_ELEM*CODE_W-1:0] trim_codes,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [CODE_W-1:0]        rd_code
);

    localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(N_ELEM);

    cal_state_t       state;
    logic             apply_en;
    logic [SEL_W-1:0] apply_sel;
    logic             apply_up;
    logic [CODE_W-1:0] codes [N_ELEM];

    msb_trim_cal_ctrl #(
        .N_ELEM (N_ELEM),
        .SEL_W  (SEL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_run   (cal_run),
        .slot_stb  (slot_stb),
        .slot_sel  (slot_sel),
        .sign_vld  (sign_vld),
        .sign_pos  (sign_pos),
        .state     (state),
        .apply_en  (apply_en),
        .apply_sel (apply_sel),
        .apply_up  (apply_up)
    );

    for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_elem
        logic hit;
        assign hit = apply_en && (apply_sel == SEL_W'(gi));

        msb_trim_cal_cell #(
            .CODE_W     (CODE_W),
            .THRESH     (THRESH),
            .RESET_CODE (RESET_CODE)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit),
            .up    (apply_up),
            .code  (codes[gi])
        );

        assign trim_codes[gi*CODE_W +: CODE_W] = codes[gi];
    end

    always_comb begin
        rd_code = '0;
        if ({1'b0, rd_sel} < SEL_LIMIT)
            rd_code = codes[rd_sel];
    end

endmodule

// File: rtl/msb_trim_cal_chk.sv
module msb_trim_cal_chk
    import msb_trim_cal_pkg::*;
#(
    parameter int N_ELEM = 15,
    parameter int CODE_W = 8,
    parameter int SEL_W  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cal_run,
    input logic                     slot_stb,
    input logic [SEL_W-1:0]         slot_sel,
    input logic                     sign_vld,
    input logic [N_ELEM*CODE_W-1:0] trim_codes,
    input cal_state_t               state
);

    logic [N_ELEM-1:0] chg;
    logic [N_ELEM-1:0] step_ok;

    for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_watch
        logic [CODE_W-1:0] prev;
        logic [CODE_W-1:0] cur;
        assign cur = trim_codes[gi*CODE_W +: CODE_W];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= cur;
            else        prev <= cur;
        end
        assign chg[gi]     = (cur != prev);
        assign step_ok[gi] = !chg[gi] || (cur == prev + 1'b1) || (cur == prev - 1'b1);
    end

    // R6: frozen and no commit pending, codes hold
    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_run && state != ST_COMMIT) |=> $stable(trim_codes));

    // R3: codes move only on the cycle after a commit
    p_change_only_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> $stable(trim_codes));

    // R2: out-of-range index leaves controller idle
    p_bad_sel_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && slot_stb && {1'b0, slot_sel} >= (SEL_W+1)'(N_ELEM)) |=> (state == ST_IDLE));

    // R7: waiting persists until polarity or freeze
    p_wait_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAIT && cal_run && !sign_vld) |=> (state == ST_AWAIT));

    // R4: at most one element changes per cycle
    p_one_elem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg));

    // R3: any change is a single LSB step
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&step_ok));

endmodule

bind msb_trim_cal msb_trim_cal_chk #(
    .N_ELEM (N_ELEM),
    .CODE_W (CODE_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_run    (cal_run),
    .slot_stb   (slot_stb),
    .slot_sel   (slot_sel),
    .sign_vld   (sign_vld),
    .trim_codes (trim_codes),
    .state      (state)
);

// File: tb/msb_trim_cal_test.sv
`timescale 1ns/1ps
module msb_trim_cal_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cal_run = 1'b0;
    logic         slot_stb = 1'b0;
    logic [3:0]   slot_sel = '0;
    logic         sign_vld = 1'b0;
    logic         sign_pos = 1'b0;
    logic [119:0] trim_codes;
    logic [3:0]   rd_sel = '0;
    logic [7:0]   rd_code;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    msb_trim_cal uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_run    (cal_run),
        .slot_stb   (slot_stb),
        .slot_sel   (slot_sel),
        .sign_vld   (sign_vld),
        .sign_pos   (sign_pos),
        .trim_codes (trim_codes),
        .rd_sel     (rd_sel),
        .rd_code    (rd_code)
    );

    task automatic chk_code(input int idx, input int exp, input string req);
        checks++;
        if (trim_codes[idx*8 +: 8] !== 8'(exp)) begin
            failures++;
            $display("FAIL %s element %0d actual=%0d expected=%0d", req, idx, trim_codes[idx*8 +: 8], exp);
        end
    endtask

    task automatic chk_rd(input int idx, input int exp, input string req);
        rd_sel = 4'(idx);
        #0.5;
        checks++;
        if (rd_code !== 8'(exp)) begin
            failures++;
            $display("FAIL %s readback %0d actual=%0d expected=%0d", req, idx, rd_code, exp);
        end
    endtask

    // one complete measurement; drives 1 ns after an edge
    task automatic meas(input int sel, input bit up);
        slot_stb = 1'b1; slot_sel = 4'(sel);
        @(posedge clk); #1;
        slot_stb = 1'b0;
        sign_vld = 1'b1; sign_pos = up;
        @(posedge clk); #1;
        sign_vld = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 15; i++) chk_code(i, 128, "R1");
        chk_rd(4, 128, "R1");
    endtask

    task automatic t_threshold;
        for (int i = 0; i < 7; i++) meas(3, 1'b1);
        chk_code(3, 128, "R3 seven ups");
        meas(3, 1'b1);
        chk_code(3, 129, "R3 eighth up");
        for (int i = 0; i < 7; i++) meas(3, 1'b0);
        chk_code(3, 129, "R3 cleared then seven downs");
        meas(3, 1'b0);
        chk_code(3, 128, "R3 eighth down");
        chk_code(2, 128, "R4 neighbour low");
        chk_code(4, 128, "R4 neighbour high");
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 1040; i++) meas(0, 1'b1);
        chk_code(0, 255, "R5 upper rail");
        for (int i = 0; i < 1040; i++) meas(14, 1'b0);
        chk_code(14, 0, "R5 lower rail");
        chk_code(1, 128, "R4 untouched");
    endtask

    task automatic t_bad_sel;
        for (int i = 0; i < 10; i++) meas(15, 1'b1);
        for (int i = 0; i < 15; i++)
            if (i != 0 && i != 14) chk_code(i, 128, "R2 index 15 ignored");
        chk_code(0, 255, "R2 index 15 ignored");
        chk_code(14, 0, "R2 index 15 ignored");
    endtask

    task automatic t_freeze;
        cal_run = 1'b0;
        for (int i = 0; i < 8; i++) meas(5, 1'b1);
        chk_code(5, 128, "R6 frozen slots");
        cal_run = 1'b1;
        for (int i = 0; i < 7; i++) meas(5, 1'b1);
        chk_code(5, 128, "R6 accumulator held");
        // abort a pending measurement
        slot_stb = 1'b1; slot_sel = 4'd5;
        @(posedge clk); #1;
        slot_stb = 1'b0; cal_run = 1'b0; sign_vld = 1'b1; sign_pos = 1'b1;
        @(posedge clk); #1;
        sign_vld = 1'b0; cal_run = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk_code(5, 128, "R6 aborted polarity");
        meas(5, 1'b1);
        chk_code(5, 129, "R6 resume");
    endtask

    task automatic t_delay;
        for (int i = 0; i < 7; i++) meas(7, 1'b1);
        slot_stb = 1'b1; slot_sel = 4'd7;
        @(posedge clk); #1;
        slot_sel = 4'd8;
        for (int i = 0; i < 5; i++) begin @(posedge clk); #1; end
        slot_stb = 1'b0;
        chk_code(7, 128, "R7 waiting");
        sign_vld = 1'b1; sign_pos = 1'b1;
        @(posedge clk); #1;
        sign_vld = 1'b0;
        chk_code(7, 128, "R3 not before commit edge");
        @(posedge clk); #1;
        chk_code(7, 129, "R7 captured element");
        chk_code(8, 128, "R7 late strobe ignored");
    endtask

    task automatic t_readback;
        chk_rd(0, 255, "R8");
        chk_rd(14, 0, "R8");
        chk_rd(7, 129, "R8");
        chk_rd(15, 0, "R8 out of range");
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset;
        cal_run = 1'b1;
        t_threshold;
        t_saturate;
        t_bad_sel;
        t_freeze;
        t_delay;
        t_readback;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule